// File: doc/BRIEF.md
# Bus Loopback Test Register

This block is a slave-side test target for an asynchronous, SRAM-style parallel bus between a microcontroller and an FPGA. It holds one 32-bit register that can exercise every data line and every word-address line of the bus. A host that writes to word address zero stores the value on the data lines. A host that writes to any other word address stores that address instead, and the write data is dropped. Every read returns the register, whatever address the read carries. The host therefore tests the data bus by writing patterns to address zero and reading them back. It tests the address bus by writing to assorted non-zero addresses and comparing each read-back value with the word address it used.

The bus strobes are active low: chip select, write enable and output enable. Each strobe passes through a two-flop synchroniser into the fabric clock. A small state machine then tracks the access. It has four states. `ST_IDLE` waits for an access. `ST_WRITE` follows a write strobe and captures the address and data on every cycle. `ST_COMMIT` loads the register for exactly one cycle. `ST_READ` enables the data-bus drivers.

The transitions are these. From `ST_IDLE` to `ST_WRITE` on synchronised chip select plus write enable in bank zero. From `ST_IDLE` to `ST_READ` on synchronised chip select plus output enable in bank zero, with write taking priority. From `ST_WRITE` to `ST_COMMIT` when write enable releases while chip select is still held. From `ST_WRITE` to `ST_IDLE` when chip select releases, which aborts the write. From `ST_COMMIT` to `ST_IDLE` unconditionally. From `ST_READ` to `ST_IDLE` when either chip select or output enable releases.

The host must hold the address and data for at least two clocks after it releases write enable. The top two of the 26 address lines select the bank, and only bank zero answers.

Top module: `bus_echo_reg`

## Requirements
- R1: Synchronous active-high reset clears the register to 0 and leaves the data bus undriven, so the first read after reset returns 0x00000000.
- R2: A committed write to word address 0 in bank 0 (address bits [23:0] all zero) loads the full 32-bit write data into the register.
- R3: A committed write to a non-zero word address in bank 0 loads address bits [23:0], zero-extended to 32 bits, into the register and discards the write data.
- R4: A read in bank 0 returns the current register value at every word address.
- R5: The data-out enable is high only while synchronised chip select and output enable are both asserted (low on the pins). Output enable without chip select, or chip select without output enable, leaves the bus undriven.
- R6: An access whose bank bits (address bits [25:24]) are non-zero is ignored. Such a write leaves the register unchanged, and such a read leaves the enable low.
- R7: A write commits exactly once, on the synchronised release of write enable while chip select is still asserted. If chip select releases on the same clock as write enable, or before it, the register is unchanged.
- R8: Every strobe passes through a two-stage synchroniser before the state machine sees it. After chip select and output enable fall, the enable is still low after two clock edges and is high after the third.
- R9: The highest word address 0xFFFFFF is stored as 0x00FFFFFF, and each of the 24 word-address bits is captured in its own position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | 26 | Bank bits [25:24] and word address [23:0] |
| bus_wdata | input | 32 | Write data from the host |
| bus_rdata | output | 32 | Read data, valid when bus_rdata_oe is high |
| bus_rdata_oe | output | 1 | Tri-state enable for the data bus |

## Verification
A fault in the capture registers or in the commit decision stays hidden until the host reads. It then appears at the next read as one specific wrong value: the data where an address was expected, a stale value, or an address with a bit missing. Walking a single one through every address bit makes a stuck bit visible within one write/read pair. A state machine stuck in `ST_READ` or `ST_WRITE` shows at the ports within a few clocks, as an enable that stays high after the strobes release or as a read that is never driven. The enable's latency after the strobe edges is checked cycle by cycle, so an extra or missing synchroniser stage is visible on the first read.

// File: rtl/bus_echo_pkg.sv
package bus_echo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_READ   = 2'd3
    } echo_state_t;
endpackage

// File: rtl/strobe_sync.sv
// Multi-stage synchroniser for active-low strobes; outputs active-high.
// STAGES must be at least 2.
module strobe_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] act
);
    for (genvar g = 0; g < N; g++) begin : g_chan
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], ~raw_n[g]};
        end
        assign act[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/echo_fsm.sv
module echo_fsm
    import bus_echo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_act,
    input  logic        we_act,
    input  logic        oe_act,
    input  logic        bank_ok,
    output echo_state_t state,
    output logic        cap_en,
    output logic        commit,
    output logic        rd_en
);
    echo_state_t nxt;
    logic        start_wr;
    logic        start_rd;

    assign start_wr = cs_act && we_act && bank_ok;
    assign start_rd = cs_act && oe_act && bank_ok;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_wr)      nxt = ST_WRITE;
                else if (start_rd) nxt = ST_READ;
            end
            ST_WRITE: begin
                if (!cs_act)       nxt = ST_IDLE;
                else if (!we_act)  nxt = ST_COMMIT;
            end
            ST_COMMIT:             nxt = ST_IDLE;
            ST_READ: begin
                if (!(cs_act && oe_act)) nxt = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        cap_en = 1'b0;
        commit = 1'b0;
        rd_en  = 1'b0;
        unique case (state)
            ST_IDLE:   cap_en = start_wr;
            ST_WRITE:  cap_en = cs_act && we_act;
            ST_COMMIT: commit = 1'b1;
            ST_READ:   rd_en  = 1'b1;
        endcase
    end
endmodule

// File: rtl/echo_store.sv
module echo_store #(
    parameter int DATA_W = 32,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              commit,
    input  logic [WORD_W-1:0] word_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [WORD_W-1:0] hold_word,
    output logic [DATA_W-1:0] hold_data,
    output logic [DATA_W-1:0] store
);
    localparam int PAD_W = DATA_W - WORD_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_word <= '0;
            hold_data <= '0;
            store     <= '0;
        end else begin
            if (cap_en) begin
                hold_word <= word_addr;
                hold_data <= wdata;
            end
            if (commit) begin
                if (hold_word == '0) store <= hold_data;
                else                 store <= {{PAD_W{1'b0}}, hold_word};
            end
        end
    end
endmodule

// File: rtl/bus_echo_reg.sv
module bus_echo_reg
    import bus_echo_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int WORD_W      = 24,
    parameter int BANK_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_cs_n,
    input  logic                     bus_we_n,
    input  logic                     bus_oe_n,
    input  logic [WORD_W+BANK_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     bus_rdata_oe
);
    localparam int ADDR_W = WORD_W + BANK_W;

    logic [2:0]        strobe_act;
    logic              cs_act;
    logic              we_act;
    logic              oe_act;
    logic              bank_ok;
    echo_state_t       state;
    logic              cap_en;
    logic              commit;
    logic              rd_en;
    logic [WORD_W-1:0] hold_word;
    logic [DATA_W-1:0] hold_data;
    logic [DATA_W-1:0] store_q;

    strobe_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_n ({bus_oe_n, bus_we_n, bus_cs_n}),
        .act   (strobe_act)
    );

    assign cs_act  = strobe_act[0];
    assign we_act  = strobe_act[1];
    assign oe_act  = strobe_act[2];
    assign bank_ok = (bus_addr[ADDR_W-1 -: BANK_W] == '0);

    echo_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cs_act  (cs_act),
        .we_act  (we_act),
        .oe_act  (oe_act),
        .bank_ok (bank_ok),
        .state   (state),
        .cap_en  (cap_en),
        .commit  (commit),
        .rd_en   (rd_en)
    );

    echo_store #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .commit    (commit),
        .word_addr (bus_addr[WORD_W-1:0]),
        .wdata     (bus_wdata),
        .hold_word (hold_word),
        .hold_data (hold_data),
        .store     (store_q)
    );

    assign bus_rdata    = store_q;
    assign bus_rdata_oe = rd_en;
endmodule

// File: rtl/bus_echo_chk.sv
module bus_echo_chk
    import bus_echo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input logic              oe_act,
    input echo_state_t       state,
    input logic              commit,
    input logic              rd_en,
    input logic [WORD_W-1:0] hold_word,
    input logic [DATA_W-1:0] hold_data,
    input logic [DATA_W-1:0] store
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (store == '0 && !rd_en));

    assert_data_load_R2: assert property (@(posedge clk) disable iff (rst)
        (commit && hold_word == '0) |=> store == $past(hold_data));

    assert_addr_load_R3: assert property (@(posedge clk) disable iff (rst)
        (commit && hold_word != '0) |=>
            (store[WORD_W-1:0] == $past(hold_word) && store[DATA_W-1:WORD_W] == '0));

    assert_drive_gated_R5: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> $past(cs_act && oe_act));

    assert_commit_from_write_R7: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(state == ST_WRITE));

    assert_single_commit_R7: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    assert_store_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(store));
endmodule

bind bus_echo_reg bus_echo_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .oe_act    (oe_act),
    .state     (state),
    .commit    (commit),
    .rd_en     (rd_en),
    .hold_word (hold_word),
    .hold_data (hold_data),
    .store     (store_q)
);

// File: tb/bus_echo_reg_bench.sv
module bus_echo_reg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [25:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdata_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [31:0] model = '0;

    always #2 clk = ~clk;

    bus_echo_reg u_bus_echo_reg (
        .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rdata_oe(rdata_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // abort=1 releases chip select on the same clock as write enable
    task automatic bus_write(input logic [25:0] a, input logic [31:0] d, input bit abort);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; we_n = 1'b0;
        repeat (6) @(negedge clk);
        we_n = 1'b1;
        if (abort) cs_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        wdata = ~d;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_read(input logic [25:0] a, output logic [31:0] d, output logic en);
        @(negedge clk);
        addr = a; cs_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(negedge clk);
        d = rdata; en = rdata_oe;
        cs_n = 1'b1; oe_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 enable drops after release", {31'b0, rdata_oe}, 32'd0);
    endtask

    task automatic read_expect(input logic [25:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        logic en;
        bus_read(a, d, en);
        check(req, {31'b0, en}, 32'd1);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        check("R1 idle enable low", {31'b0, rdata_oe}, 32'd0);
        read_expect(26'h000005, 32'h0, "R1 reset value");
    endtask

    task automatic t_data();
        logic [31:0] pats [4] = '{32'hA5A55A5A, 32'hFFFFFFFF, 32'h00000000, 32'h12345678};
        foreach (pats[i]) begin
            bus_write(26'h0, pats[i], 1'b0);
            model = pats[i];
            read_expect(26'(i * 7 + 3), model, "R2 data load / R4 any address");
        end
        read_expect(26'h0, model, "R4 read at address zero");
        read_expect(26'hFFFFFF, model, "R4 read at top address");
    endtask

    task automatic t_addr();
        bus_write(26'h000004, 32'hDEADBEEF, 1'b0);
        model = 32'h4;
        read_expect(26'h0, model, "R3 address stored, data discarded");
        bus_write(26'hFFFFFF, 32'h0, 1'b0);
        model = 32'h00FFFFFF;
        read_expect(26'h123, model, "R9 top address zero-extended");
        for (int b = 0; b < 24; b++) begin
            bus_write(26'(1 << b), 32'hCAFEF00D, 1'b0);
            model = 32'(1 << b);
            read_expect(26'h0, model, "R9 walking address bit");
        end
    endtask

    task automatic t_bank();
        logic [31:0] d;
        logic en;
        bus_write(26'h0, 32'h0BADC0DE, 1'b0);
        model = 32'h0BADC0DE;
        bus_write(26'h1000000, 32'h11111111, 1'b0);
        bus_write(26'h2000010, 32'h22222222, 1'b0);
        read_expect(26'h0, model, "R6 other-bank write ignored");
        bus_read(26'h3000000, d, en);
        check("R6 other-bank read undriven", {31'b0, en}, 32'd0);
    endtask

    task automatic t_abort();
        bus_write(26'h0, 32'h55AA55AA, 1'b0);
        model = 32'h55AA55AA;
        bus_write(26'h0, 32'h99999999, 1'b1);
        bus_write(26'h000040, 32'h0, 1'b1);
        read_expect(26'h0, model, "R7 aborted write leaves register");
        bus_write(26'h0, 32'h01020304, 1'b0);
        model = 32'h01020304;
        read_expect(26'h0, model, "R7 normal commit after abort");
    endtask

    task automatic t_gating();
        @(negedge clk);
        oe_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 output enable alone", {31'b0, rdata_oe}, 32'd0);
        oe_n = 1'b1; cs_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 chip select alone", {31'b0, rdata_oe}, 32'd0);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_latency();
        @(negedge clk);
        addr = 26'h0; cs_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 enable low after two edges", {31'b0, rdata_oe}, 32'd0);
        @(negedge clk);
        check("R8 enable high after third edge", {31'b0, rdata_oe}, 32'd1);
        check("R8 data on first driven cycle", rdata, model);
        cs_n = 1'b1; oe_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_data();
        t_addr();
        t_gating();
        t_latency();
        t_bank();
        t_abort();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule